// File: doc/BRIEF.md
# SCL Phase Generator

This block derives the two halves of a serial clock line from the system clock for a two-wire bus master. A prescaler divides the system clock by a power of two and emits a base tick. A phase sequencer counts base ticks: first through a low phase, then through a high phase, and then it starts again. The bit engine downstream reads the phase indicator to drive the clock line. It also uses two single-cycle strobes: one for each base tick and one for each phase change.

All three settings come in one 20-bit timing word. The prescaler exponent B is in bits 3:0, the low count L is in bits 15:12, and the high count H is in bits 19:16. Bits 11:4 are unused. The counts are stored minus one, so one full period lasts 2^B x ((H+1)+(L+1)) system clocks.

While enable is low, the block sits idle in the low phase and copies the timing word on every clock. While enable is high, the word is copied only at the end of each high phase. A change to the word therefore never splits a period.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is high, or on the clock after enable was sampled low, scl_high, base_tick and edge_tick are all 0.
- R2: While enabled, base_tick is a one-cycle pulse that repeats every 2^B system clocks, where B is timing word bits 3:0. Every phase contains exactly (its count + 1) base_tick pulses, including the pulse in its first cycle.
- R3: Every low phase (scl_high = 0) lasts (L+1) x 2^B clocks, where L is timing word bits 15:12.
- R4: Every high phase (scl_high = 1) lasts (H+1) x 2^B clocks, where H is timing word bits 19:16.
- R5: Each period begins with its low phase. scl_high first rises exactly (L+1) x 2^B clocks after the first clock edge at which enable is sampled high.
- R6: edge_tick is 1 in the first cycle of every new phase and at no other time, and it is only ever 1 together with base_tick.
- R7: When enable drops in the middle of a period and is raised again, the sequence restarts from the beginning of a full low phase.
- R8: A timing word that changes while enabled takes effect only at the next period boundary (the end of a high phase). Each phase of the current period keeps the old B, H and L.
- R9: Count fields of 0 give phases of exactly one base tick each. With B = 0, H = 0 and L = 0, scl_high toggles on every clock.
- R10: The largest exponent, B = 15, gives base ticks 32768 clocks apart.
- R11: While enable is low, the timing word is copied on every clock. The first enabled period therefore uses the word that was present one clock before enable rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the generator idle and restarts it |
| timing_word | input | 20 | B at bits 3:0, L at bits 15:12, H at bits 19:16 |
| base_tick | output | 1 | One-cycle pulse per prescaler wrap |
| edge_tick | output | 1 | One-cycle pulse in the first cycle of each phase |
| scl_high | output | 1 | Phase indicator: 1 = high phase, 0 = low phase |

## Verification
All three outputs come from registers. Each one moves on the edge after the prescaler reaches its limit, so the first rise of scl_high falls exactly (L+1) x 2^B edges after the first enabled edge. Each later phase holds for exactly its stated number of cycles.

The bench drives inputs and samples outputs on falling edges. It counts falling-edge samples from the enable edge up to the first rise, then counts the run length of each level. The edge_tick check expects a 1 in the first sample of each run and a 0 in every other sample. The base_tick check counts the pulses inside each run. Disable and restart effects are due one edge after the stimulus, and the bench samples them at the next falling edge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_hold.sv
// Shadow copy of the timing fields: tracks the word while idle,
// otherwise reloads only at a period boundary.
module scl_cfg_hold #(
  parameter int FW       = 4,
  parameter int WORD_W   = 20,
  parameter int BASE_LSB = 0,
  parameter int LOW_LSB  = 12,
  parameter int HIGH_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              boundary,
  input  logic [WORD_W-1:0] word,
  output logic [FW-1:0]     base_q,
  output logic [FW-1:0]     low_q,
  output logic [FW-1:0]     high_q
);
  wire unused_word_bits = ^word;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (!en || boundary) begin
      base_q <= word[BASE_LSB +: FW];
      low_q  <= word[LOW_LSB  +: FW];
      high_q <= word[HIGH_LSB +: FW];
    end
  end
endmodule

// File: rtl/scl_prescaler.sv
// Power-of-two divider: tick is high for one cycle every 2^base clocks.
module scl_prescaler #(
  parameter int FW    = 4,
  parameter int PRE_W = (1 << FW) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [FW-1:0] base,
  output logic          tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] lim;

  always_comb lim = ~({PRE_W{1'b1}} << base);
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
// Counts base ticks through the low phase, then the high phase.
module scl_phase_seq
  import scl_gen_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [FW-1:0] low_cnt,
  input  logic [FW-1:0] high_cnt,
  output logic          boundary,
  output logic          scl_high,
  output logic          base_tick_q,
  output logic          edge_tick_q
);
  scl_phase_e    ph;
  logic [FW-1:0] cnt;
  logic          last;
  logic          step;

  always_comb begin
    last     = (cnt == ((ph == PH_HIGH) ? high_cnt : low_cnt));
    step     = tick && last;
    boundary = step && (ph == PH_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph          <= PH_LOW;
      cnt         <= '0;
      base_tick_q <= 1'b0;
      edge_tick_q <= 1'b0;
    end else begin
      base_tick_q <= tick;
      edge_tick_q <= step;
      if (step) begin
        ph  <= (ph == PH_HIGH) ? PH_LOW : PH_HIGH;
        cnt <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign scl_high = (ph == PH_HIGH);
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int FW       = 4,
  parameter int WORD_W   = 20,
  parameter int BASE_LSB = 0,
  parameter int LOW_LSB  = 12,
  parameter int HIGH_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] timing_word,
  output logic              base_tick,
  output logic              edge_tick,
  output logic              scl_high
);
  localparam int PRE_W = (1 << FW) - 1;

  logic [FW-1:0] base_q;
  logic [FW-1:0] low_q;
  logic [FW-1:0] high_q;
  logic          tick;
  logic          boundary;

  scl_cfg_hold #(
    .FW(FW), .WORD_W(WORD_W), .BASE_LSB(BASE_LSB),
    .LOW_LSB(LOW_LSB), .HIGH_LSB(HIGH_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst), .en(en), .boundary(boundary), .word(timing_word),
    .base_q(base_q), .low_q(low_q), .high_q(high_q)
  );

  scl_prescaler #(.FW(FW), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(en), .base(base_q), .tick(tick)
  );

  scl_phase_seq #(.FW(FW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .low_cnt(low_q), .high_cnt(high_q), .boundary(boundary),
    .scl_high(scl_high), .base_tick_q(base_tick), .edge_tick_q(edge_tick)
  );
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          scl_high,
  input logic          base_tick,
  input logic          edge_tick,
  input logic [FW-1:0] base_now
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_high && !base_tick && !edge_tick));

  // R6
  edge_marks_change_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (edge_tick == (scl_high != $past(scl_high))));

  // R6
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    edge_tick |-> base_tick);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (base_tick && base_now != '0) |=> !base_tick);
endmodule

bind scl_phase_gen scl_phase_gen_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .scl_high(scl_high),
  .base_tick(base_tick), .edge_tick(edge_tick), .base_now(base_q)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [19:0] timing_word = '0;
  logic        base_tick, edge_tick, scl_high;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_phase_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .timing_word(timing_word),
    .base_tick(base_tick), .edge_tick(edge_tick), .scl_high(scl_high)
  );

  function automatic logic [19:0] mk(int b, int h, int l, logic [7:0] junk);
    return {h[3:0], l[3:0], junk, b[3:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(int b, int h, int l, logic [7:0] junk);
    en = 1'b0;
    timing_word = mk(b, h, l, junk);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  // Counts falling edges until scl_high is seen high.
  task automatic run_to_rise(output int n, output int stray);
    n = 0; stray = 0;
    do begin
      @(negedge clk);
      n++;
      if (!scl_high && edge_tick) stray++;
    end while (!scl_high && n < 70000);
  endtask

  // Current sample is the first of a phase at 'level'.
  task automatic phase(logic level, output int len, output int bt, output int bad);
    len = 0; bt = 0; bad = 0;
    do begin
      len++;
      bt += int'(base_tick);
      if ((len == 1) ? !edge_tick : edge_tick) bad++;
      @(negedge clk);
    end while (scl_high == level && len < 70000);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    check(!scl_high && !base_tick && !edge_tick, "R1 reset outputs", int'({scl_high, base_tick, edge_tick}), 0);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);
    check(!scl_high && !base_tick && !edge_tick, "R1 idle outputs", int'({scl_high, base_tick, edge_tick}), 0);
  endtask

  task automatic t_case(int b, int h, int l, logic [7:0] junk, bit full, string tag);
    int n, s, len, bt, bad;
    start(b, h, l, junk);
    run_to_rise(n, s);
    check(n == ((l + 1) << b), {"R5 first rise ", tag}, n, (l + 1) << b);
    check(s == 0, {"R6 no edge in first low ", tag}, s, 0);
    phase(1'b1, len, bt, bad);
    check(len == ((h + 1) << b), {"R4 high length ", tag}, len, (h + 1) << b);
    check(bt == h + 1, {"R2 ticks in high ", tag}, bt, h + 1);
    check(bad == 0, {"R6 edge marks high ", tag}, bad, 0);
    if (full) begin
      phase(1'b0, len, bt, bad);
      check(len == ((l + 1) << b), {"R3 low length ", tag}, len, (l + 1) << b);
      check(bt == l + 1, {"R2 ticks in low ", tag}, bt, l + 1);
      check(bad == 0, {"R6 edge marks low ", tag}, bad, 0);
      phase(1'b1, len, bt, bad);
      check(len == ((h + 1) << b), {"R4 second high ", tag}, len, (h + 1) << b);
    end
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!scl_high && !base_tick && !edge_tick, {"R1 after disable ", tag}, int'({scl_high, base_tick, edge_tick}), 0);
  endtask

  task automatic t_restart();
    int n, s;
    start(2, 2, 3, 8'h00);
    run_to_rise(n, s);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!scl_high, "R7 drop mid high", int'(scl_high), 0);
    en = 1'b1;
    run_to_rise(n, s);
    check(n == 16, "R7 full low after restart", n, 16);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_change_in_high();
    int n, s, len, bt, bad;
    start(1, 4, 2, 8'h00);
    run_to_rise(n, s);
    timing_word = mk(0, 1, 3, 8'h00);
    phase(1'b1, len, bt, bad);
    check(len == 10, "R8 high keeps old setting", len, 10);
    phase(1'b0, len, bt, bad);
    check(len == 4, "R8 next low uses new setting", len, 4);
    phase(1'b1, len, bt, bad);
    check(len == 2, "R8 next high uses new setting", len, 2);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_change_in_low();
    int n, s, len, bt, bad;
    start(1, 2, 5, 8'h00);
    repeat (3) @(negedge clk);
    timing_word = mk(0, 0, 0, 8'h00);
    run_to_rise(n, s);
    check(n + 3 == 12, "R8 low keeps old setting", n + 3, 12);
    phase(1'b1, len, bt, bad);
    check(len == 6, "R8 same period high keeps old", len, 6);
    phase(1'b0, len, bt, bad);
    check(len == 1, "R8 new low after boundary", len, 1);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_word_sample();
    int n, s;
    en = 1'b0;
    timing_word = mk(0, 0, 6, 8'h00);
    @(negedge clk);
    @(negedge clk);
    timing_word = mk(0, 0, 2, 8'h00);
    @(negedge clk);
    en = 1'b1;
    run_to_rise(n, s);
    check(n == 3, "R11 word one clock before enable", n, 3);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_case(0, 0, 0, 8'h00, 1'b1, "R9 minimum");
    t_case(0, 8, 7, 8'hFF, 1'b1, "recommended");
    t_case(2, 3, 1, 8'h5A, 1'b1, "b2");
    t_case(12, 0, 0, 8'h00, 1'b1, "b12");
    t_case(15, 0, 0, 8'h00, 1'b0, "R10 max base");
    t_restart();
    t_change_in_high();
    t_change_in_low();
    t_word_sample();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule